// File: doc/BRIEF.md
# Issue Slot Latch Enable Pipeline

This block produces per-slot clock enables for the back-end stage registers of a superscalar core that issues up to `W` instructions per cycle. The issue stage delivers a bitmap with one bit per issue slot. A set 1 marks a slot that holds an issued instruction, and a 0 marks an empty slot. Copies of this bitmap ride through four ungated register stages beside the register-read, execute, memory and writeback stage registers. Each copy is the enable vector for that stage's per-slot data registers, so a slot's register is only clocked while the slot holds an instruction.

The block also forms the enables for the rename-stage registers from what decode reports in the previous cycle. Decode reports which slots of the fetch group are valid and which are predicted-taken branches. Every valid slot up to and including the first valid predicted-taken branch is enabled. Every slot after that branch is cut off.

A synchronous flush empties every in-flight copy, including the rename enables, at the next edge. The fetch, decode and issue output registers are not gated and are not handled here.

Top module: `slot_enable_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, every enable output is 0 after that edge.
- R2: After an edge where `rst` and `flush` are low, `en_rf` bit i equals `iss_occ` bit i as sampled at that edge (1 = slot occupied, 0 = empty).
- R3: After an edge where `rst` and `flush` are low, `en_ex` equals the value `en_rf` had before that edge.
- R4: After an edge where `rst` and `flush` are low, `en_mem` equals the value `en_ex` had before that edge.
- R5: After an edge where `rst` and `flush` are low, `en_wb` equals the value `en_mem` had before that edge.
- R6: Slot index 0 is the oldest slot in the group. If the lowest-indexed slot with both `dec_valid` and `dec_taken` set is slot j, then after the edge `en_ren` bits 0..j equal `dec_valid` bits 0..j, and bits above j are 0.
- R7: If no slot has both `dec_valid` and `dec_taken` set, then after the edge `en_ren` equals `dec_valid`.
- R8: When `flush` is high at an edge, all five enable outputs are 0 after that edge, whatever the other inputs are.
- R9: A `dec_taken` bit on a slot whose `dec_valid` bit is 0 does not cut off any later slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all in-flight enables |
| dec_valid | input | W | Decode: slot holds a fetched instruction on the predicted path |
| dec_taken | input | W | Decode: slot is a branch predicted taken |
| iss_occ | input | W | Issue slot occupancy bitmap |
| en_ren | output | W | Rename stage register enables |
| en_rf | output | W | Register-read stage register enables |
| en_ex | output | W | Execute stage register enables |
| en_mem | output | W | Memory stage register enables |
| en_wb | output | W | Writeback stage register enables |

## Verification
Two things can land on the same edge: a flush, and a new occupancy bitmap together with a truncating decode group. The bench provokes this by raising `flush` in cycles where every input is nonzero and a taken branch sits mid-group. It then expects all five outputs at zero, and in the following cycle it expects the pipe to refill from the fresh inputs alone. Random cycles without flush are compared against a shift-register model and a prefix-truncation function, both computed in the bench.

// File: rtl/slot_en_pkg.sv
package slot_en_pkg;
  // Back-end stages carried after issue, in pipeline order.
  typedef enum int {
    ST_RF  = 0,
    ST_EX  = 1,
    ST_MEM = 2,
    ST_WB  = 3
  } back_stage_e;

  localparam int N_BACK = 4;
endpackage

// File: rtl/occ_stage.sv
module occ_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Free-running copy of the slot bitmap; never gated itself.
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= d;
  end
endmodule

// File: rtl/rename_trim.sv
module rename_trim #(
  parameter int W = 8
) (
  input  logic [W-1:0] valid,
  input  logic [W-1:0] taken,
  output logic [W-1:0] keep
);
  logic cut;
  always_comb begin
    cut = 1'b0;
    for (int i = 0; i < W; i++) begin
      keep[i] = valid[i] & ~cut;
      cut     = cut | (valid[i] & taken[i]);
    end
  end
endmodule

// File: rtl/slot_enable_pipe.sv
module slot_enable_pipe
  import slot_en_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic [W-1:0] dec_valid,
  input  logic [W-1:0] dec_taken,
  input  logic [W-1:0] iss_occ,
  output logic [W-1:0] en_ren,
  output logic [W-1:0] en_rf,
  output logic [W-1:0] en_ex,
  output logic [W-1:0] en_mem,
  output logic [W-1:0] en_wb
);
  localparam int CHAIN_LEN = N_BACK + 1;

  logic [W-1:0] ren_next;
  logic [W-1:0] chain [CHAIN_LEN];

  rename_trim #(.W(W)) u_trim (
    .valid (dec_valid),
    .taken (dec_taken),
    .keep  (ren_next)
  );

  occ_stage #(.W(W)) u_ren (
    .clk (clk),
    .rst (rst),
    .clr (flush),
    .d   (ren_next),
    .q   (en_ren)
  );

  assign chain[0] = iss_occ;

  for (genvar s = 0; s < N_BACK; s++) begin : g_back
    occ_stage #(.W(W)) u_stg (
      .clk (clk),
      .rst (rst),
      .clr (flush),
      .d   (chain[s]),
      .q   (chain[s+1])
    );
  end

  assign en_rf  = chain[ST_RF  + 1];
  assign en_ex  = chain[ST_EX  + 1];
  assign en_mem = chain[ST_MEM + 1];
  assign en_wb  = chain[ST_WB  + 1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (en_ren == '0 && en_rf == '0 && en_ex == '0 && en_mem == '0 && en_wb == '0)); // R1
  AST_RF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !flush |=> en_rf == $past(iss_occ)); // R2
  AST_EX_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !flush |=> en_ex == $past(en_rf)); // R3
  AST_MEM_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !flush |=> en_mem == $past(en_ex)); // R4
  AST_WB_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !flush |=> en_wb == $past(en_mem)); // R5
  AST_REN_SUBSET: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (en_ren & ~$past(dec_valid)) == '0); // R6
  AST_REN_NO_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!flush && (dec_valid & dec_taken) == '0) |=> en_ren == $past(dec_valid)); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flush |=> (en_ren == '0 && en_rf == '0 && en_ex == '0 && en_mem == '0 && en_wb == '0)); // R8
endmodule

// File: tb/slot_enable_pipe_tb_top.sv
`timescale 1ns/1ps
module slot_enable_pipe_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic [W-1:0] dec_valid = '0;
  logic [W-1:0] dec_taken = '0;
  logic [W-1:0] iss_occ = '0;
  logic [W-1:0] en_ren, en_rf, en_ex, en_mem, en_wb;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ren, m_rf, m_ex, m_mem, m_wb;

  always #2.5 clk = ~clk;

  slot_enable_pipe #(.W(W)) dut_i (
    .clk, .rst, .flush, .dec_valid, .dec_taken, .iss_occ,
    .en_ren, .en_rf, .en_ex, .en_mem, .en_wb
  );

  function automatic logic [W-1:0] trim_ref(logic [W-1:0] v, logic [W-1:0] t);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      r[i] = v[i];
      if (v[i] && t[i]) return r;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R6/R7 rename"}, en_ren, m_ren);
    chk({ctx, " R2 rf"},  en_rf,  m_rf);
    chk({ctx, " R3 ex"},  en_ex,  m_ex);
    chk({ctx, " R4 mem"}, en_mem, m_mem);
    chk({ctx, " R5 wb"},  en_wb,  m_wb);
  endtask

  // Drive at negedge, clock once, compare at next negedge.
  task automatic step(logic fl, logic [W-1:0] v, logic [W-1:0] t, logic [W-1:0] o, string ctx);
    flush = fl; dec_valid = v; dec_taken = t; iss_occ = o;
    if (fl || rst) begin
      m_ren = '0; m_rf = '0; m_ex = '0; m_mem = '0; m_wb = '0;
    end else begin
      m_wb = m_mem; m_mem = m_ex; m_ex = m_rf; m_rf = o;
      m_ren = trim_ref(v, t);
    end
    @(posedge clk);
    @(negedge clk);
    check_all(ctx);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ren = '0; m_rf = '0; m_ex = '0; m_mem = '0; m_wb = '0;
    // R1: reset with busy inputs
    @(negedge clk);
    step(1'b0, '1, '0, '1, "R1 reset");
    step(1'b0, 8'hA5, 8'h00, 8'h3C, "R1 reset");
    rst = 1'b0;

    // Directed rename cases (R6, R7, R9)
    step(1'b0, 8'hFF, 8'h00, 8'hFF, "R7 no taken");
    step(1'b0, 8'hFF, 8'h01, 8'h01, "R6 taken slot0");
    step(1'b0, 8'hFF, 8'h80, 8'h80, "R6 taken last");
    step(1'b0, 8'hFF, 8'h24, 8'h00, "R6 two taken");
    step(1'b0, 8'hF7, 8'h08, 8'h55, "R9 taken on invalid");
    step(1'b0, 8'h0F, 8'hF0, 8'hAA, "R9 taken above valid");
    step(1'b0, 8'h00, 8'hFF, 8'h00, "R7 empty group");

    // R8: flush while everything is busy, then refill
    step(1'b0, 8'hFF, 8'h10, 8'hFF, "R8 prefill");
    step(1'b1, 8'hFF, 8'h10, 8'hFF, "R8 flush busy");
    step(1'b0, 8'h3F, 8'h04, 8'h81, "R8 refill");
    step(1'b0, 8'h00, 8'h00, 8'h00, "R2 drain zero");

    // Random mix; occasional flush
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] v, t, o;
      logic fl;
      v  = W'($urandom);
      t  = ($urandom % 3 == 0) ? W'(1 << ($urandom % W)) : W'($urandom & $urandom);
      o  = W'($urandom);
      fl = ($urandom % 16 == 0);
      step(fl, v, t, o, fl ? "R8 rand flush" : "R2 rand");
    end

    // Drain the pipe to show zeros shifting through
    for (int n = 0; n < 5; n++) step(1'b0, '0, '0, '0, "R5 drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule